// File: doc/BRIEF.md
# Daisy-Chained Serial Command Decoder

This block is the serial slave for one device in a stack of identical devices wired as a daisy chain. It takes an active-low chip-select, a serial clock and a serial data input, and brings them into the system clock domain through a short synchronizer. Each transaction opens with an 8-bit command byte. The byte carries a fixed address prefix, a 2-bit operation code and an even-parity bit. The operation either loads 16-bit write words into a holding register, returns the holding register, returns the active balance state, or makes the held word active.

Write words for the entire stack go through one shared 16-bit shift register per device. The serial output is taken from the most significant bit of that register, so each device hands data on to the next one 16 bits later. When chip-select rises, each device keeps the last 16 bits it received. A framing fault locks the interface until the next chip-select cycle. A command byte with bad parity also turns off the active balance controls at once.

Top module: `ddc_top`

## Requirements
- R1: After reset the balance-control output `bal_o` is zero, `sdo_o` is low, and a readback returns 16'h000F.
- R2: When the five most significant command bits differ from 10101 and parity is even, all later bits in that frame are ignored. The holding register keeps its value and `sdo_o` stays low.
- R3: A command byte with odd parity clears `bal_o` to zero while chip-select is still low, whatever its prefix holds. The data that follows in that frame is ignored.
- R4: A write command byte (bits 2:1 = 00, byte 8'hA9) clears the holding register to 16'h0000, even when no data follows.
- R5: A write frame of N×16 data bits whose final word has a correct CRC leaves that final word in the holding register.
- R6: A write frame whose data length is not a multiple of 16 leaves the holding register cleared.
- R7: A final word whose low 4 bits differ from the CRC of its upper 12 bits is not latched. The CRC uses polynomial x^4+x+1 with initial value 0, fed MSB first.
- R8: A write never changes `bal_o`. An execute byte (bits 2:1 = 11, byte 8'hAF) copies holding bits 15:4 to `bal_o`.
- R9: A readback byte (bits 2:1 = 01, byte 8'hAA) shifts the holding register out on `sdo_o`, MSB first, one bit per following serial clock rise.
- R10: A status byte (bits 2:1 = 10, byte 8'hAC) shifts out `bal_o` followed by its 4-bit CRC, MSB first.
- R11: During write data, `sdo_o` repeats `sdi_i` delayed by exactly 16 serial clocks. The first 16 output bits after the command are zero.
- R12: Serial clock edges while chip-select is high change neither the holding register nor `bal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csb_i | input | 1 | Active-low chip-select |
| sck_i | input | 1 | Serial clock; data sampled on its rising edge |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output to the next device |
| bal_o | output | 12 | Active balance controls, six A/B pairs |

## Verification
The main path is driven with several kinds of write frame: a single valid word, a three-word chain, a frame 4 bits too long, a word with a corrupted CRC, and an empty write. Together these separate last-word capture from first-word capture, length checking from CRC checking, and clearing at command time from clearing at commit time. Every write is followed by a readback and, where relevant, an execute and a status read, so both the holding path and the active path are observed at the ports. Command bytes with a bad prefix and with bad parity are each sent with a valid word after them, which shows whether the lockout and the immediate abort behave differently. Serial clock pulses while chip-select is high check that idle traffic is ignored.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int CTRL_W = 12;
  localparam int CRC_W  = 4;
  localparam int WORD_W = CTRL_W + CRC_W;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_STAT  = 2'b10,
    OP_EXEC  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    F_IDLE,
    F_CMD,
    F_DATA,
    F_LOCK
  } fstate_e;

  // x^4 + x + 1, zero seed, MSB first
  function automatic logic [CRC_W-1:0] crc4(input logic [CTRL_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = CTRL_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ 4'b0011;
    end
    return c;
  endfunction
endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic csb_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic cs_low,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sdi_s
);
  logic [STAGES-1:0] cs_pipe, sck_pipe, sdi_pipe;
  logic cs_last, sck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_pipe  <= '1;
      sck_pipe <= '0;
      sdi_pipe <= '0;
      cs_last  <= 1'b1;
      sck_last <= 1'b0;
    end else begin
      cs_pipe  <= {cs_pipe[STAGES-2:0], csb_i};
      sck_pipe <= {sck_pipe[STAGES-2:0], sck_i};
      sdi_pipe <= {sdi_pipe[STAGES-2:0], sdi_i};
      cs_last  <= cs_pipe[STAGES-1];
      sck_last <= sck_pipe[STAGES-1];
    end
  end

  assign cs_low   = ~cs_pipe[STAGES-1];
  assign cs_fall  = cs_last & ~cs_pipe[STAGES-1];
  assign cs_rise  = ~cs_last & cs_pipe[STAGES-1];
  assign sck_rise = ~sck_last & sck_pipe[STAGES-1] & ~cs_pipe[STAGES-1];
  assign sdi_s    = sdi_pipe[STAGES-1];
endmodule

// File: rtl/ddc_frame.sv
module ddc_frame
  import ddc_pkg::*;
#(
  parameter logic [4:0] ADDR = 5'b10101
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_fall,
  input  logic cs_rise,
  input  logic bit_stb,
  input  logic sdi,
  output op_e  op_o,
  output logic cmd_ok_o,
  output logic par_err_o,
  output logic commit_o,
  output logic data_phase_o,
  output logic locked_o
);
  localparam int MOD_W = $clog2(WORD_W);

  fstate_e    state;
  logic [2:0] bit_idx;
  logic [6:0] cmd_sr;
  logic [7:0] cmd_full;
  op_e        op_q;
  logic       cmd_ok_q, par_err_q, commit_q;
  logic [MOD_W-1:0] data_mod;
  logic       data_any;

  assign cmd_full = {cmd_sr, sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= F_IDLE;
      bit_idx   <= '0;
      cmd_sr    <= '0;
      op_q      <= OP_WRITE;
      cmd_ok_q  <= 1'b0;
      par_err_q <= 1'b0;
      commit_q  <= 1'b0;
      data_mod  <= '0;
      data_any  <= 1'b0;
    end else begin
      cmd_ok_q  <= 1'b0;
      par_err_q <= 1'b0;
      commit_q  <= 1'b0;
      if (cs_fall) begin
        state    <= F_CMD;
        bit_idx  <= '0;
        data_mod <= '0;
        data_any <= 1'b0;
      end else if (cs_rise) begin
        if (state == F_DATA && op_q == OP_WRITE && data_any && data_mod == '0)
          commit_q <= 1'b1;
        state <= F_IDLE;
      end else if (bit_stb) begin
        case (state)
          F_CMD: begin
            cmd_sr  <= cmd_full[6:0];
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) begin
              if (^cmd_full) begin
                par_err_q <= 1'b1;
                state     <= F_LOCK;
              end else if (cmd_full[7:3] != ADDR) begin
                state <= F_LOCK;
              end else begin
                op_q     <= op_e'(cmd_full[2:1]);
                cmd_ok_q <= 1'b1;
                state    <= F_DATA;
              end
            end
          end
          F_DATA: begin
            data_mod <= data_mod + 1'b1;
            data_any <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign op_o         = op_q;
  assign cmd_ok_o     = cmd_ok_q;
  assign par_err_o    = par_err_q;
  assign commit_o     = commit_q;
  assign data_phase_o = (state == F_DATA);
  assign locked_o     = (state == F_LOCK);

  // R2: a locked frame never returns to data phase before a new chip-select
  p_lock_stays_r2: assert property (@(posedge clk) disable iff (rst)
    (state == F_LOCK && !cs_fall) |=> state != F_DATA);
endmodule

// File: rtl/ddc_shreg.sv
module ddc_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         shift_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (load)   q <= load_val;
    else if (shift)  q <= {q[W-2:0], shift_in};
  end

  // R11: each shift advances the chain by one position toward the MSB
  p_shift_msb_r11: assert property (@(posedge clk) disable iff (rst)
    (shift && !clr && !load) |=> q[W-1] == $past(q[W-2]));
endmodule

// File: rtl/ddc_top.sv
module ddc_top
  import ddc_pkg::*;
#(
  parameter int              SYNC_STAGES  = 2,
  parameter logic [4:0]      ADDR         = 5'b10101,
  parameter logic [15:0]     HOLD_RST     = 16'h000F,
  parameter logic [11:0]     ACTIVE_RST   = 12'h000,
  parameter bit              TOP_OF_STACK = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        csb_i,
  input  logic        sck_i,
  input  logic        sdi_i,
  output logic        sdo_o,
  output logic [11:0] bal_o
);
  logic cs_low, cs_fall, cs_rise, sck_rise, sdi_s;
  op_e  op;
  logic cmd_ok, par_err, commit, data_phase, locked;
  logic [WORD_W-1:0] sr_q, sr_load_val, hold;
  logic [CTRL_W-1:0] active;
  logic sr_load, sr_shift, sr_in, word_good;

  ddc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .csb_i(csb_i), .sck_i(sck_i), .sdi_i(sdi_i),
    .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sdi_s(sdi_s)
  );

  ddc_frame #(.ADDR(ADDR)) u_frame (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .bit_stb(sck_rise), .sdi(sdi_s), .op_o(op), .cmd_ok_o(cmd_ok),
    .par_err_o(par_err), .commit_o(commit), .data_phase_o(data_phase),
    .locked_o(locked)
  );

  assign sr_load     = cmd_ok && (op == OP_READ || op == OP_STAT);
  assign sr_load_val = (op == OP_READ) ? hold : {active, crc4(active)};
  assign sr_shift    = data_phase && sck_rise;
  assign sr_in       = (TOP_OF_STACK && op != OP_WRITE) ? 1'b0 : sdi_s;

  ddc_shreg #(.W(WORD_W)) u_shreg (
    .clk(clk), .rst(rst), .clr(cs_fall), .load(sr_load),
    .load_val(sr_load_val), .shift(sr_shift), .shift_in(sr_in), .q(sr_q)
  );

  assign word_good = (crc4(sr_q[WORD_W-1:CRC_W]) == sr_q[CRC_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst)                          hold <= HOLD_RST;
    else if (cmd_ok && op == OP_WRITE) hold <= '0;
    else if (commit && word_good)     hold <= sr_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                          active <= ACTIVE_RST;
    else if (par_err)                 active <= '0;
    else if (cmd_ok && op == OP_EXEC) active <= hold[WORD_W-1:CRC_W];
  end

  assign sdo_o = sr_q[WORD_W-1];
  assign bal_o = active;

  // R3: bad parity leaves no balance control on
  p_par_clear_r3: assert property (@(posedge clk) disable iff (rst)
    par_err |=> active == '0);
  // R8: write command and write commit leave the active controls alone
  p_write_keep_r8: assert property (@(posedge clk) disable iff (rst)
    ((cmd_ok && op == OP_WRITE) || commit) |=> $stable(active));
  // R8: execute copies the held control bits
  p_exec_copy_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && op == OP_EXEC) |=> active == $past(hold[WORD_W-1:CRC_W]));
  // R2: a locked frame moves neither shift chain nor holding register
  p_lock_still_r2: assert property (@(posedge clk) disable iff (rst)
    (locked && !cs_fall && !commit) |=> $stable(sr_q) && $stable(hold));
  // R12: no state change while chip-select is high
  p_idle_still_r12: assert property (@(posedge clk) disable iff (rst)
    (!cs_low && !commit && !cmd_ok && !par_err) |=> $stable(hold) && $stable(active));
endmodule

// File: tb/ddc_top_tb.sv
module ddc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csb = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [11:0] bal;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { string req; logic [15:0] val; } item_t;
  item_t exp_q[$];
  logic [15:0] got_q[$];

  logic [15:0] wbuf [4];
  logic [15:0] gbuf [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  ddc_top dut_i (
    .clk(clk), .rst(rst), .csb_i(csb), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .bal_o(bal)
  );

  function automatic logic [3:0] ref_crc(input logic [11:0] c);
    logic [15:0] r;
    r = {c, 4'b0000};
    for (int i = 15; i >= 4; i--)
      if (r[i]) r = r ^ (16'b10011 << (i - 4));
    return r[3:0];
  endfunction

  function automatic logic [15:0] mk(input logic [11:0] c);
    return {c, ref_crc(c)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] v, input int n, output logic [15:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      sdi = v[15 - i];
      wait_clk(HB);
      got = {got[14:0], sdo};
      sck = 1'b1;
      wait_clk(HB);
      sck = 1'b0;
    end
  endtask

  task automatic cs_on();
    csb = 1'b0;
    wait_clk(2 * HB);
  endtask

  task automatic cs_off();
    wait_clk(HB);
    csb = 1'b1;
    wait_clk(4 * HB);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    logic [15:0] g;
    xfer({c, 8'h00}, 8, g);
  endtask

  task automatic do_write(input logic [7:0] c, input int nw, input int extra);
    logic [15:0] g;
    cs_on();
    send_cmd(c);
    for (int k = 0; k < nw; k++) begin
      xfer(wbuf[k], 16, g);
      gbuf[k] = g;
    end
    if (extra > 0) xfer(16'hFFFF, extra, g);
    cs_off();
  endtask

  // driver: announce expectation, run the read frame, hand result to monitor
  task automatic read_word(input logic [7:0] c, input string req, input logic [15:0] exp);
    logic [15:0] g;
    exp_q.push_back('{req, exp});
    cs_on();
    send_cmd(c);
    xfer(16'h0000, 16, g);
    cs_off();
    got_q.push_back(g);
  endtask

  // monitor
  initial begin
    item_t e;
    logic [15:0] g;
    forever begin
      wait (got_q.size() > 0);
      g = got_q.pop_front();
      e = exp_q.pop_front();
      check(g == e.val, e.req, g, e.val);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] g;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    // R1 reset state
    check(bal == 12'h000, "R1", {4'h0, bal}, 16'h0000);
    check(sdo == 1'b0, "R1", {15'h0, sdo}, 16'h0000);
    read_word(8'hAA, "R1 R9", 16'h000F);
    read_word(8'hAC, "R10", mk(12'h000));

    // R5 single word
    wbuf[0] = mk(12'hA5C);
    do_write(8'hA9, 1, 0);
    read_word(8'hAA, "R5 R9", mk(12'hA5C));
    check(bal == 12'h000, "R8", {4'h0, bal}, 16'h0000);

    // R8 execute, R10 status
    cs_on(); send_cmd(8'hAF); cs_off();
    check(bal == 12'hA5C, "R8", {4'h0, bal}, 16'h0A5C);
    read_word(8'hAC, "R10", mk(12'hA5C));

    // R5 chain of three, R11 pass-through
    wbuf[0] = mk(12'h123); wbuf[1] = mk(12'h456); wbuf[2] = mk(12'h9E1);
    do_write(8'hA9, 3, 0);
    check(gbuf[0] == 16'h0000, "R11", gbuf[0], 16'h0000);
    check(gbuf[1] == wbuf[0], "R11", gbuf[1], wbuf[0]);
    check(gbuf[2] == wbuf[1], "R11", gbuf[2], wbuf[1]);
    read_word(8'hAA, "R5", mk(12'h9E1));
    check(bal == 12'hA5C, "R8", {4'h0, bal}, 16'h0A5C);

    // R6 length not a multiple of 16
    wbuf[0] = mk(12'h3C3);
    do_write(8'hA9, 1, 4);
    read_word(8'hAA, "R6", 16'h0000);

    // R7 bad CRC
    wbuf[0] = mk(12'h777) ^ 16'h0001;
    do_write(8'hA9, 1, 0);
    read_word(8'hAA, "R7", 16'h0000);

    // R4 empty write clears
    wbuf[0] = mk(12'h5A5);
    do_write(8'hA9, 1, 0);
    do_write(8'hA9, 0, 0);
    read_word(8'hAA, "R4", 16'h0000);

    // R2 wrong prefix locks out
    wbuf[0] = mk(12'h5A5);
    do_write(8'hA9, 1, 0);
    wbuf[0] = mk(12'h0F0); wbuf[1] = mk(12'h0F0);
    do_write(8'h28, 2, 0);
    check(gbuf[1] == 16'h0000, "R2", gbuf[1], 16'h0000);
    read_word(8'hAA, "R2", mk(12'h5A5));

    // R3 bad parity with wrong prefix
    cs_on(); send_cmd(8'hAF); cs_off();
    check(bal == 12'h5A5, "R8", {4'h0, bal}, 16'h05A5);
    cs_on();
    send_cmd(8'h29);
    wait_clk(2 * HB);
    check(bal == 12'h000, "R3", {4'h0, bal}, 16'h0000);
    xfer(mk(12'hFFF), 16, g);
    cs_off();
    read_word(8'hAA, "R3", mk(12'h5A5));

    // R3 bad parity with correct prefix
    cs_on(); send_cmd(8'hAF); cs_off();
    cs_on();
    send_cmd(8'hA8);
    wait_clk(2 * HB);
    check(bal == 12'h000, "R3", {4'h0, bal}, 16'h0000);
    cs_off();

    // R12 clocks with chip-select high
    cs_on(); send_cmd(8'hAF); cs_off();
    xfer(mk(12'hBAD), 16, g);
    check(bal == 12'h5A5, "R12", {4'h0, bal}, 16'h05A5);
    read_word(8'hAA, "R12", mk(12'h5A5));

    wait (got_q.size() == 0);
    wait_clk(4);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard actual=%h expected=%h", exp_q.size(), 0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule